// File: doc/BRIEF.md
# Adaptive Torus Route and Virtual-Channel Allocator

This block decides where one incoming packet header goes next in a two-dimensional torus on-chip network. Each header carries a destination coordinate pair and a misroute counter. The block also sees the occupancy of every virtual channel on the four outgoing links, and the misroute count of the packet that holds each busy channel. From these it picks one output link (east, west, north, south or local ejection) and one virtual channel on it. It also returns the header's updated misroute count. If it can make no legal choice, it reports a stall.

Virtual channel 0 on every link is the escape channel and is used only with dimension-order routing: the x coordinate is corrected first, then y. Channels 1 and above are adaptive. A packet first tries a free adaptive channel on a direction that shortens its torus distance. If none is free, it takes the escape channel when the waiting rule allows it. If the escape channel is barred by the waiting rule, the packet takes a free adaptive channel in a direction that does not bring it closer, and its misroute count goes up by one. A packet whose count has reached the configured ceiling may use only the escape channel. The decision is registered, so the response appears one clock after the request.

Top module: `adaptive_torus_router`

## Requirements
- R1: While reset is held, and after it, until a request has been sampled, rsp_grant and rsp_stall are both 0.
- R2: A request sampled on a clock edge yields either rsp_grant=1 or rsp_stall=1 on the output registered at that edge, and never both. A cycle with req_valid=0 yields both 0 one cycle later.
- R3: A request whose destination equals (loc_x, loc_y) is granted on rsp_port=4 (local), rsp_vc=0, with its count unchanged and rsp_misroute=0, whatever the channel state.
- R4: The per-dimension distance is (dest - local) modulo the ring size. A distance d with 0 < d <= size/2 makes the positive direction productive (east for x, north for y). A larger d makes the negative direction productive (west, south). A distance of exactly half the ring counts as positive. Port codes: east 0, west 1, north 2, south 3.
- R5: A packet below the count ceiling is granted on the first productive direction, in the order east, west, north, south, that has a free adaptive channel. It gets the lowest-numbered free channel among 1..NUM_VC-1, with its count unchanged and rsp_misroute=0.
- R6: Otherwise the escape channel 0 is used on the dimension-order direction: the productive x direction if one exists, else the productive y direction. It is granted when that channel is free or when its occupant's count is greater than or equal to the packet's count. The packet's count is unchanged.
- R7: An escape channel that is busy with an occupant whose count is lower than the packet's count is never granted to that packet.
- R8: When R7 bars the escape channel and the packet is below the ceiling, the packet is granted on the first non-productive direction, in the order east, west, north, south, with a free adaptive channel. The lowest such channel is used, rsp_dr is the request count plus one, and rsp_misroute=1.
- R9: A packet whose count equals DR_MAX uses only the escape channel under the R6 rule. It never receives an adaptive channel and never misroutes.
- R10: When none of R3, R5, R6 or R8 applies, the response is rsp_stall=1 with rsp_grant=0 and all other response fields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_x | input | $clog2(X_SIZE) | Local x coordinate of this switch |
| loc_y | input | $clog2(Y_SIZE) | Local y coordinate of this switch |
| req_valid | input | 1 | A header is presented this cycle |
| req_dst_x | input | $clog2(X_SIZE) | Destination x coordinate |
| req_dst_y | input | $clog2(Y_SIZE) | Destination y coordinate |
| req_dr | input | $clog2(DR_MAX+1) | Misroute count carried by the header |
| vc_busy | input | 4*NUM_VC | Busy flag per channel, bit d*NUM_VC+v for direction d, channel v |
| vc_occ_dr | input | 4*NUM_VC*DRW | Occupant misroute count per channel, same ordering, DRW bits each |
| rsp_grant | output | 1 | A route was chosen |
| rsp_stall | output | 1 | No legal route this cycle |
| rsp_port | output | 3 | Chosen output port code |
| rsp_vc | output | $clog2(NUM_VC) | Chosen virtual channel |
| rsp_dr | output | DRW | Updated misroute count for the header |
| rsp_misroute | output | 1 | The chosen direction moves away from the destination |

## Verification
The first sweep covers every local and destination pair of a 4x4 torus with all channels free. It separates the local ejection case and the shortest-direction choice, including the exact half-ring tie, and shows that x is served before y. The second sweep fixes the switch position and steps through every destination, every busy pattern of all eight channels, every header count and three occupant counts. Lower, equal and higher occupant counts tell an allowed wait on the escape channel apart from a barred one. Header counts below and at the ceiling tell the misroute fallback apart from the forced escape and the stall. Idle cycles between the sweeps check that the response clears when no request is present.

// File: rtl/tor_pkg.sv
package tor_pkg;
    localparam int NUM_DIR = 4;
    localparam logic [2:0] PORT_LOCAL = 3'd4;
endpackage

// File: rtl/tor_ring_dist.sv
module tor_ring_dist #(
    parameter int RING = 4,
    localparam int CW = (RING > 1) ? $clog2(RING) : 1
) (
    input  logic [CW-1:0] here,
    input  logic [CW-1:0] dest,
    output logic          pos,
    output logic          neg
);
    localparam logic [CW:0] RW   = (CW+1)'(RING);
    localparam logic [CW:0] HALF = (CW+1)'(RING / 2);

    logic [CW:0] wrap_d;
    logic [CW:0] dist_d;

    always_comb begin
        wrap_d = {1'b0, dest} + RW - {1'b0, here};
        dist_d = (wrap_d >= RW) ? wrap_d - RW : wrap_d;
        pos    = (dist_d != '0) && (dist_d <= HALF);
        neg    = (dist_d != '0) && (dist_d > HALF);
    end
endmodule

// File: rtl/tor_vc_alloc.sv
module tor_vc_alloc
    import tor_pkg::*;
#(
    parameter int NUM_VC = 2,
    parameter int DR_MAX = 3,
    parameter int VCW    = 1,
    parameter int DRW    = 2
) (
    input  logic                            is_local,
    input  logic [NUM_DIR-1:0]              prod,
    input  logic [1:0]                      dor_dir,
    input  logic [DRW-1:0]                  pkt_dr,
    input  logic [NUM_DIR*NUM_VC-1:0]       busy,
    input  logic [NUM_DIR*NUM_VC*DRW-1:0]   occ_dr,
    output logic                            grant,
    output logic [2:0]                      port,
    output logic [VCW-1:0]                  vc,
    output logic [DRW-1:0]                  dr,
    output logic                            misroute
);
    logic [NUM_DIR-1:0] ad_free;
    logic [VCW-1:0]     ad_vc [NUM_DIR];
    logic               sat, esc_ok;
    logic [DRW-1:0]     esc_occ;
    logic               p_hit, m_hit;
    logic [1:0]         p_dir, m_dir;

    always_comb begin
        for (int d = 0; d < NUM_DIR; d++) begin
            ad_free[d] = 1'b0;
            ad_vc[d]   = '0;
            for (int v = NUM_VC - 1; v >= 1; v--) begin
                if (!busy[d*NUM_VC+v]) begin
                    ad_free[d] = 1'b1;
                    ad_vc[d]   = VCW'(v);
                end
            end
        end
    end

    always_comb begin
        sat     = (pkt_dr == DRW'(DR_MAX));
        esc_occ = occ_dr[(int'(dor_dir)*NUM_VC)*DRW +: DRW];
        esc_ok  = !busy[int'(dor_dir)*NUM_VC] || (esc_occ >= pkt_dr);
        p_hit = 1'b0; p_dir = 2'd0;
        m_hit = 1'b0; m_dir = 2'd0;
        for (int d = NUM_DIR - 1; d >= 0; d--) begin
            if (prod[d] && ad_free[d]) begin
                p_hit = 1'b1;
                p_dir = 2'(d);
            end
            if (!prod[d] && ad_free[d]) begin
                m_hit = 1'b1;
                m_dir = 2'(d);
            end
        end
        grant = 1'b0; port = '0; vc = '0; dr = '0; misroute = 1'b0;
        if (is_local) begin
            grant = 1'b1;
            port  = PORT_LOCAL;
            dr    = pkt_dr;
        end else if (!sat && p_hit) begin
            grant = 1'b1;
            port  = {1'b0, p_dir};
            vc    = ad_vc[p_dir];
            dr    = pkt_dr;
        end else if (esc_ok) begin
            grant = 1'b1;
            port  = {1'b0, dor_dir};
            dr    = pkt_dr;
        end else if (!sat && m_hit) begin
            grant    = 1'b1;
            port     = {1'b0, m_dir};
            vc       = ad_vc[m_dir];
            dr       = pkt_dr + DRW'(1);
            misroute = 1'b1;
        end
    end
endmodule

// File: rtl/adaptive_torus_router.sv
module adaptive_torus_router
    import tor_pkg::*;
#(
    parameter int X_SIZE = 4,
    parameter int Y_SIZE = 4,
    parameter int NUM_VC = 2,
    parameter int DR_MAX = 3,
    localparam int XW  = (X_SIZE > 1) ? $clog2(X_SIZE) : 1,
    localparam int YW  = (Y_SIZE > 1) ? $clog2(Y_SIZE) : 1,
    localparam int VCW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int DRW = (DR_MAX > 0) ? $clog2(DR_MAX + 1) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [XW-1:0]                 loc_x,
    input  logic [YW-1:0]                 loc_y,
    input  logic                          req_valid,
    input  logic [XW-1:0]                 req_dst_x,
    input  logic [YW-1:0]                 req_dst_y,
    input  logic [DRW-1:0]                req_dr,
    input  logic [4*NUM_VC-1:0]           vc_busy,
    input  logic [4*NUM_VC*DRW-1:0]       vc_occ_dr,
    output logic                          rsp_grant,
    output logic                          rsp_stall,
    output logic [2:0]                    rsp_port,
    output logic [VCW-1:0]                rsp_vc,
    output logic [DRW-1:0]                rsp_dr,
    output logic                          rsp_misroute
);
    typedef struct packed {
        logic           grant;
        logic           stall;
        logic [2:0]     port;
        logic [VCW-1:0] vc;
        logic [DRW-1:0] dr;
        logic           misroute;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic px, nx, py, ny;
    logic [1:0] dor_dir;
    logic a_grant, a_mis;
    logic [2:0] a_port;
    logic [VCW-1:0] a_vc;
    logic [DRW-1:0] a_dr;

    tor_ring_dist #(.RING(X_SIZE)) u_dx (.here(loc_x), .dest(req_dst_x), .pos(px), .neg(nx));
    tor_ring_dist #(.RING(Y_SIZE)) u_dy (.here(loc_y), .dest(req_dst_y), .pos(py), .neg(ny));

    assign dor_dir = px ? 2'd0 : (nx ? 2'd1 : (py ? 2'd2 : 2'd3));

    tor_vc_alloc #(.NUM_VC(NUM_VC), .DR_MAX(DR_MAX), .VCW(VCW), .DRW(DRW)) u_alloc (
        .is_local (!(px || nx || py || ny)),
        .prod     ({ny, py, nx, px}),
        .dor_dir  (dor_dir),
        .pkt_dr   (req_dr),
        .busy     (vc_busy),
        .occ_dr   (vc_occ_dr),
        .grant    (a_grant),
        .port     (a_port),
        .vc       (a_vc),
        .dr       (a_dr),
        .misroute (a_mis)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            if (a_grant) begin
                rsp_d.grant    = 1'b1;
                rsp_d.port     = a_port;
                rsp_d.vc       = a_vc;
                rsp_d.dr       = a_dr;
                rsp_d.misroute = a_mis;
            end else begin
                rsp_d.stall = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_grant    = rsp_q.grant;
    assign rsp_stall    = rsp_q.stall;
    assign rsp_port     = rsp_q.port;
    assign rsp_vc       = rsp_q.vc;
    assign rsp_dr       = rsp_q.dr;
    assign rsp_misroute = rsp_q.misroute;

    // R2
    resp_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_grant || rsp_stall) |-> $past(req_valid));

    // R10
    grant_stall_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_grant && rsp_stall));

    // R8
    misroute_count_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_grant && rsp_misroute) |-> (rsp_dr == $past(req_dr) + DRW'(1)) && (rsp_vc != '0));

    // R9
    ceiling_escape_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_grant && $past(req_dr) == DRW'(DR_MAX) && rsp_port != PORT_LOCAL)
        |-> (rsp_vc == '0) && !rsp_misroute);

    // R3
    local_eject_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_grant && rsp_port == PORT_LOCAL)
        |-> $past(req_dst_x == loc_x && req_dst_y == loc_y));

    // R5
    count_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_grant && !rsp_misroute) |-> rsp_dr == $past(req_dr));
endmodule

// File: tb/adaptive_torus_router_test.sv
module adaptive_torus_router_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] loc_x = '0, loc_y = '0, req_dst_x = '0, req_dst_y = '0, req_dr = '0;
    logic req_valid = 1'b0;
    logic [7:0] vc_busy = '0;
    logic [15:0] vc_occ_dr = '0;
    logic rsp_grant, rsp_stall, rsp_misroute;
    logic [2:0] rsp_port;
    logic [0:0] rsp_vc;
    logic [1:0] rsp_dr;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 0;

    adaptive_torus_router uut (
        .clk(clk), .rst(rst), .loc_x(loc_x), .loc_y(loc_y),
        .req_valid(req_valid), .req_dst_x(req_dst_x), .req_dst_y(req_dst_y),
        .req_dr(req_dr), .vc_busy(vc_busy), .vc_occ_dr(vc_occ_dr),
        .rsp_grant(rsp_grant), .rsp_stall(rsp_stall), .rsp_port(rsp_port),
        .rsp_vc(rsp_vc), .rsp_dr(rsp_dr), .rsp_misroute(rsp_misroute)
    );

    always #2 clk = ~clk;

    function automatic logic [8:0] pack(input int g, input int s, input int p,
                                        input int v, input int d, input int m);
        return {1'(g), 1'(s), 3'(p), 1'(v), 2'(d), 1'(m)};
    endfunction

    task automatic ref_route(input int lx, input int ly, input int dx, input int dy,
                             input int dr, input logic [7:0] busy, input int occ,
                             output logic [8:0] exp, output string tag);
        int ddx, ddy, dor;
        bit sat, eok;
        bit prod [4];
        ddx = (dx - lx + 4) % 4;
        ddy = (dy - ly + 4) % 4;
        prod[0] = (ddx != 0) && (ddx <= 2);
        prod[1] = (ddx > 2);
        prod[2] = (ddy != 0) && (ddy <= 2);
        prod[3] = (ddy > 2);
        sat = (dr == 3);
        if (dx == lx && dy == ly) begin
            exp = pack(1, 0, 4, 0, dr, 0); tag = "R3"; return;
        end
        if (!sat) begin
            for (int d = 0; d < 4; d++) begin
                if (prod[d] && !busy[d*2+1]) begin
                    exp = pack(1, 0, d, 1, dr, 0); tag = "R5"; return;
                end
            end
        end
        dor = prod[0] ? 0 : (prod[1] ? 1 : (prod[2] ? 2 : 3));
        eok = !busy[dor*2] || (occ >= dr);
        if (eok) begin
            exp = pack(1, 0, dor, 0, dr, 0); tag = sat ? "R9" : "R6"; return;
        end
        if (!sat) begin
            for (int d = 0; d < 4; d++) begin
                if (!prod[d] && !busy[d*2+1]) begin
                    exp = pack(1, 0, d, 1, dr + 1, 1); tag = "R8 R7"; return;
                end
            end
        end
        exp = pack(0, 1, 0, 0, 0, 0); tag = sat ? "R9" : "R10";
    endtask

    task automatic check(input string tag, input logic [8:0] exp);
        logic [8:0] got;
        got = {rsp_grant, rsp_stall, rsp_port, rsp_vc, rsp_dr, rsp_misroute};
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            if (n_fails < 20)
                $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic one(input int lx, input int ly, input int dx, input int dy,
                       input int dr, input logic [7:0] busy, input int occ,
                       input string force_tag);
        logic [8:0] exp;
        string tag;
        loc_x = 2'(lx); loc_y = 2'(ly);
        req_dst_x = 2'(dx); req_dst_y = 2'(dy); req_dr = 2'(dr);
        vc_busy = busy;
        for (int i = 0; i < 8; i++) vc_occ_dr[i*2 +: 2] = 2'(occ);
        req_valid = 1'b1;
        ref_route(lx, ly, dx, dy, dr, busy, occ, exp, tag);
        if (force_tag != "") tag = {force_tag, " ", tag};
        @(negedge clk);
        check(tag, exp);
    endtask

    task automatic idle_check();
        req_valid = 1'b0;
        @(negedge clk);
        // R2: no request gives an empty response
        check("R2", 9'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", 9'd0);
        req_valid = 1'b1;
        @(negedge clk);
        check("R1", 9'd0);
        rst = 1'b0;
        idle_check();
        // R4 R3: every position pair, all channels free
        for (int lx = 0; lx < 4; lx++)
            for (int ly = 0; ly < 4; ly++)
                for (int dx = 0; dx < 4; dx++)
                    for (int dy = 0; dy < 4; dy++)
                        one(lx, ly, dx, dy, 0, 8'h00, 0, "R4");
        idle_check();
        // R5 R6 R7 R8 R9 R10: congestion sweep at a fixed switch
        for (int dx = 0; dx < 4; dx++)
            for (int dy = 0; dy < 4; dy++)
                for (int b = 0; b < 256; b++)
                    for (int dr = 0; dr < 4; dr++)
                        for (int oi = 0; oi < 3; oi++)
                            one(1, 2, dx, dy, dr, 8'(b), (oi == 2) ? 3 : oi, "");
        idle_check();
        idle_check();
        finish_run();
    end
endmodule